// File: doc/BRIEF.md
# Wildcard Road Finder for Coarse Track Patterns

The block holds a small bank of coarse track patterns. Each pattern stores one superstrip identifier for each of eight detector layers, and each layer of a pattern may instead be marked as a wildcard. An event begins with a start pulse, which clears every pattern's layer flags. The event's hits then arrive one word per cycle, each word giving a layer number and a superstrip identifier. A hit sets the flag of every pattern whose stored identifier on that layer equals the hit's identifier. The comparison leaves out the low bits counted by that layer's don't-care setting.

When the end-of-event pulse comes, the block takes a snapshot of the patterns whose layers are all satisfied, either flagged or wildcard. These are the roads. It hands them out one per accepted transfer, lowest pattern index first, and then raises a one-cycle completion pulse. The bank is written one layer at a time through a plain write port. The don't-care counts are a static configuration vector, and each layer has its own count, so outer layers can be matched more coarsely than inner ones.

Top module: `amf_matcher`

## Requirements
- R1: After reset no road is offered and no completion pulse is given, and an end-of-event pulse that no start pulse preceded produces neither.
- R2: A pattern whose non-wildcard layers each received a hit equal to the stored identifier during the event is reported as a road.
- R3: A pattern with any non-wildcard layer that received no matching hit during the event is not reported.
- R4: A wildcard layer counts as satisfied even when no hit at all arrives on that layer.
- R5: A pattern never holds more than two wildcard layers. A write that asks for a wildcard on a layer, while two other layers of that pattern are already wildcards, stores the identifier but not the wildcard.
- R6: Layer l compares only the identifier bits at and above bit d, where d is the 4-bit value at cfg_dc[4l+3:4l]. A value of 12 or more makes any hit on that layer match.
- R7: Layer flags stay set for the rest of the event once they are set, whatever hits follow. A start pulse clears them all. Hits given outside an open event (before its start pulse) are ignored.
- R8: A hit whose layer number is 8 or more changes no flag.
- R9: Roads are offered in strictly ascending index order, one per cycle in which road_valid and road_ready are both high. While road_ready is low, road_valid and road_idx hold.
- R10: road_done is high for exactly one cycle. It comes two cycles after the last road is accepted, or two cycles after the end-of-event pulse when there are no roads, and road_valid is low at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dc | input | 32 | Don't-care bit count, 4 bits for each layer |
| wr_en | input | 1 | Bank write strobe |
| wr_pat | input | 4 | Pattern index to write |
| wr_layer | input | 4 | Layer to write; values of 8 and above are ignored |
| wr_ssid | input | 12 | Superstrip identifier to store |
| wr_wild | input | 1 | Request a wildcard on this layer |
| sof | input | 1 | Start-of-event pulse; clears the flags |
| hit_valid | input | 1 | Hit word present |
| hit_layer | input | 4 | Layer of the hit |
| hit_ssid | input | 12 | Superstrip identifier of the hit |
| eoe | input | 1 | End-of-event pulse; starts road readout |
| road_valid | output | 1 | A road index is offered |
| road_idx | output | 4 | Index of the offered road |
| road_ready | input | 1 | Consumer accepts the offered road |
| road_done | output | 1 | One-cycle pulse after the last road |

## Verification
Each of the 16 stored patterns is tried in turn with a complete hit set mixed with near-miss hits. This separates correct matching and sticky flags from flags that are overwritten. Each pattern is also sent one layer short, which tells real per-layer AND logic apart from a wildcard that leaks or an OR over layers. The don't-care runs first flip bits below each layer's own count and then flip the bit just above it, and the out-of-range layer runs send otherwise correct identifiers on layers 8 to 15. Together these tell a per-layer mask from a global one, and a dropped hit from a hit that is folded onto a valid layer. Readout is driven both with a consumer that is always ready and with one that stalls, to check ordering, hold under back-pressure and the timing of the completion pulse.

// File: rtl/amf_pkg.sv
package amf_pkg;
    typedef enum logic [0:0] {
        PH_IDLE    = 1'b0,
        PH_COLLECT = 1'b1
    } phase_e;
endpackage

// File: rtl/amf_bank.sv
module amf_bank #(
    parameter int unsigned NP = 16,
    parameter int unsigned NL = 8,
    parameter int unsigned SW = 12,
    parameter int unsigned DW = 4,
    parameter int unsigned LW = 4,
    parameter int unsigned MAXWILD = 2,
    localparam int unsigned PW = $clog2(NP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NL*DW-1:0]       dc_cfg_i,
    input  logic                   wr_en_i,
    input  logic [PW-1:0]          wr_pat_i,
    input  logic [LW-1:0]          wr_layer_i,
    input  logic [SW-1:0]          wr_ssid_i,
    input  logic                   wr_wild_i,
    input  logic                   clear_i,
    input  logic                   hit_en_i,
    input  logic [LW-1:0]          hit_layer_i,
    input  logic [SW-1:0]          hit_ssid_i,
    output logic [NP-1:0]          matched_o,
    output logic [NP-1:0][NL-1:0]  wild_o
);
    typedef struct packed {
        logic [NP-1:0][NL-1:0][SW-1:0] ssid;
        logic [NP-1:0][NL-1:0]         wild;
        logic [NP-1:0][NL-1:0]         flag;
    } bank_t;

    bank_t st_d, st_q;

    logic [NL-1:0][SW-1:0] care;
    logic [NL-1:0]         sel;
    logic [NP-1:0][NL-1:0] lay_hit;

    // Per-layer ternary mask and hit steering; out-of-range layers select nothing.
    for (genvar l = 0; l < NL; l++) begin : g_layer
        assign care[l] = {SW{1'b1}} << dc_cfg_i[l*DW +: DW];
        assign sel[l]  = hit_en_i && (hit_layer_i == LW'(l));
    end

    for (genvar p = 0; p < NP; p++) begin : g_pat
        for (genvar l = 0; l < NL; l++) begin : g_cmp
            assign lay_hit[p][l] = sel[l] &&
                (((hit_ssid_i ^ st_q.ssid[p][l]) & care[l]) == '0);
        end
        assign matched_o[p] = &(st_q.flag[p] | st_q.wild[p]);
    end

    assign wild_o = st_q.wild;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.flag = '0;
        end else begin
            st_d.flag = st_q.flag | lay_hit;
        end
        if (wr_en_i) begin
            for (int p = 0; p < NP; p++) begin
                for (int l = 0; l < NL; l++) begin
                    if (wr_pat_i == PW'(p) && wr_layer_i == LW'(l)) begin
                        st_d.ssid[p][l] = wr_ssid_i;
                        st_d.wild[p][l] = wr_wild_i &&
                            ($countones(st_q.wild[p] & ~(NL'(1) << l)) < MAXWILD);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/amf_road_scan.sv
module amf_road_scan #(
    parameter int unsigned NP = 16,
    localparam int unsigned PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [NP-1:0] load_vec_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [PW-1:0] idx_o,
    output logic          done_o,
    output logic          busy_o
);
    typedef struct packed {
        logic          active;
        logic [NP-1:0] pend;
        logic          done;
    } scan_t;

    scan_t sc_d, sc_q;
    logic [PW-1:0] low;
    logic          any;

    // Lowest pending index wins.
    always_comb begin
        low = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (sc_q.pend[i]) begin
                low = PW'(i);
            end
        end
    end

    assign any = |sc_q.pend;

    always_comb begin
        sc_d      = sc_q;
        sc_d.done = 1'b0;
        if (load_i) begin
            sc_d.active = 1'b1;
            sc_d.pend   = load_vec_i;
        end else if (sc_q.active) begin
            if (!any) begin
                sc_d.active = 1'b0;
                sc_d.done   = 1'b1;
            end else if (ready_i) begin
                sc_d.pend[low] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign valid_o = sc_q.active && any;
    assign idx_o   = low;
    assign done_o  = sc_q.done;
    assign busy_o  = sc_q.active;
endmodule

// File: rtl/amf_matcher.sv
module amf_matcher
    import amf_pkg::*;
#(
    parameter int unsigned NP = 16,
    parameter int unsigned NL = 8,
    parameter int unsigned SW = 12,
    parameter int unsigned DW = 4,
    localparam int unsigned PW = $clog2(NP),
    localparam int unsigned LW = $clog2(NL) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NL*DW-1:0] cfg_dc,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_pat,
    input  logic [LW-1:0]    wr_layer,
    input  logic [SW-1:0]    wr_ssid,
    input  logic             wr_wild,
    input  logic             sof,
    input  logic             hit_valid,
    input  logic [LW-1:0]    hit_layer,
    input  logic [SW-1:0]    hit_ssid,
    input  logic             eoe,
    output logic             road_valid,
    output logic [PW-1:0]    road_idx,
    input  logic             road_ready,
    output logic             road_done
);
    typedef struct packed {
        phase_e phase;
    } top_t;

    top_t tp_d, tp_q;

    logic                  busy_w;
    logic                  clear_w;
    logic                  hit_en_w;
    logic                  load_w;
    logic [NP-1:0]         matched_w;
    logic [NP-1:0][NL-1:0] wild_w;

    // Start pulse wins over hits and end-of-event in the same cycle.
    assign clear_w  = sof && !busy_w;
    assign hit_en_w = hit_valid && (tp_q.phase == PH_COLLECT) && !busy_w && !sof && !eoe;
    assign load_w   = eoe && (tp_q.phase == PH_COLLECT) && !busy_w && !sof;

    always_comb begin
        tp_d = tp_q;
        if (clear_w) begin
            tp_d.phase = PH_COLLECT;
        end else if (load_w) begin
            tp_d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_q <= '{phase: PH_IDLE};
        end else begin
            tp_q <= tp_d;
        end
    end

    amf_bank #(
        .NP(NP), .NL(NL), .SW(SW), .DW(DW), .LW(LW), .MAXWILD(2)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .dc_cfg_i   (cfg_dc),
        .wr_en_i    (wr_en),
        .wr_pat_i   (wr_pat),
        .wr_layer_i (wr_layer),
        .wr_ssid_i  (wr_ssid),
        .wr_wild_i  (wr_wild),
        .clear_i    (clear_w),
        .hit_en_i   (hit_en_w),
        .hit_layer_i(hit_layer),
        .hit_ssid_i (hit_ssid),
        .matched_o  (matched_w),
        .wild_o     (wild_w)
    );

    amf_road_scan #(.NP(NP)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_w),
        .load_vec_i(matched_w),
        .ready_i   (road_ready),
        .valid_o   (road_valid),
        .idx_o     (road_idx),
        .done_o    (road_done),
        .busy_o    (busy_w)
    );
endmodule

// File: rtl/amf_matcher_chk.sv
module amf_matcher_chk #(
    parameter int unsigned NP = 16,
    parameter int unsigned NL = 8,
    parameter int unsigned PW = 4,
    parameter int unsigned LW = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  road_valid,
    input logic                  road_ready,
    input logic [PW-1:0]         road_idx,
    input logic                  road_done,
    input logic                  hit_valid,
    input logic [LW-1:0]         hit_layer,
    input logic                  sof,
    input logic                  eoe,
    input logic                  wr_en,
    input logic [NP-1:0]         matched,
    input logic [NP-1:0][NL-1:0] wild
);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        road_valid && !road_ready |=> road_valid && $stable(road_idx));

    p_ascend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        road_valid && road_ready |=> !road_valid || (road_idx > $past(road_idx)));

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        road_done |-> !road_valid);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        road_done |=> !road_done);

    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && (int'(hit_layer) >= NL) && !sof && !eoe && !wr_en |=> $stable(matched));

    for (genvar p = 0; p < NP; p++) begin : g_cap
        p_wild_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(wild[p]) <= 2);
    end
endmodule

bind amf_matcher amf_matcher_chk #(.NP(NP), .NL(NL), .PW(PW), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .road_valid(road_valid),
    .road_ready(road_ready),
    .road_idx  (road_idx),
    .road_done (road_done),
    .hit_valid (hit_valid),
    .hit_layer (hit_layer),
    .sof       (sof),
    .eoe       (eoe),
    .wr_en     (wr_en),
    .matched   (matched_w),
    .wild      (wild_w)
);

// File: tb/sim_amf_matcher.sv
`timescale 1ns/1ps
module sim_amf_matcher;
    localparam int NP = 16;
    localparam int NL = 8;
    localparam int SW = 12;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL*DW-1:0] cfg_dc = '0;
    logic wr_en = 1'b0;
    logic [3:0] wr_pat = '0;
    logic [3:0] wr_layer = '0;
    logic [SW-1:0] wr_ssid = '0;
    logic wr_wild = 1'b0;
    logic sof = 1'b0;
    logic hit_valid = 1'b0;
    logic [3:0] hit_layer = '0;
    logic [SW-1:0] hit_ssid = '0;
    logic eoe = 1'b0;
    logic road_valid;
    logic [3:0] road_idx;
    logic road_ready = 1'b0;
    logic road_done;

    always #5 clk = ~clk;

    amf_matcher u0 (
        .clk(clk), .rst_n(rst_n), .cfg_dc(cfg_dc),
        .wr_en(wr_en), .wr_pat(wr_pat), .wr_layer(wr_layer),
        .wr_ssid(wr_ssid), .wr_wild(wr_wild),
        .sof(sof), .hit_valid(hit_valid), .hit_layer(hit_layer),
        .hit_ssid(hit_ssid), .eoe(eoe),
        .road_valid(road_valid), .road_idx(road_idx),
        .road_ready(road_ready), .road_done(road_done)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [SW-1:0] m_ssid [NP][NL];
    bit            m_wild [NP][NL];
    int            m_dc   [NL];
    int            h_layer [64];
    logic [SW-1:0] h_ssid  [64];
    int            nh = 0;
    logic [15:0]   lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL R10 watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic write_layer(input int p, input int l, input logic [SW-1:0] s, input bit w);
        int others;
        wr_en = 1'b1; wr_pat = 4'(p); wr_layer = 4'(l); wr_ssid = s; wr_wild = w;
        @(negedge clk);
        wr_en = 1'b0; wr_wild = 1'b0;
        if (l < NL) begin
            others = 0;
            for (int k = 0; k < NL; k++) if (k != l && m_wild[p][k]) others++;
            m_ssid[p][l] = s;
            m_wild[p][l] = w && (others < 2);
        end
    endtask

    task automatic set_dc(input int l, input int v);
        cfg_dc[l*DW +: DW] = 4'(v);
        m_dc[l] = v;
    endtask

    task automatic add_hit(input int l, input logic [SW-1:0] s);
        h_layer[nh] = l;
        h_ssid[nh] = s;
        nh++;
    endtask

    task automatic drive_hits();
        for (int i = 0; i < nh; i++) begin
            hit_valid = 1'b1; hit_layer = 4'(h_layer[i]); hit_ssid = h_ssid[i];
            @(negedge clk);
        end
        hit_valid = 1'b0;
    endtask

    function automatic bit model_match(input int q);
        bit found;
        logic [SW-1:0] care;
        for (int l = 0; l < NL; l++) begin
            if (!m_wild[q][l]) begin
                found = 1'b0;
                care = {SW{1'b1}} << m_dc[l];
                for (int i = 0; i < nh; i++)
                    if (h_layer[i] == l && ((h_ssid[i] ^ m_ssid[q][l]) & care) == '0)
                        found = 1'b1;
                if (!found) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    // Open an event, send the hit list, close it and drain the roads.
    task automatic run_event(input bit stall, input string tag);
        int exp_idx [NP];
        int ne, k, held, last, t;
        bit rdy, got_done;
        ne = 0;
        for (int q = 0; q < NP; q++) if (model_match(q)) begin exp_idx[ne] = q; ne++; end
        sof = 1'b1; @(negedge clk); sof = 1'b0;
        drive_hits();
        eoe = 1'b1; @(negedge clk); eoe = 1'b0;
        k = 0; held = -1; last = -1; got_done = 1'b0;
        for (t = 0; t < 200; t++) begin
            rdy = stall ? ((t % 3) != 1) : 1'b1;
            road_ready = rdy;
            if (road_done) begin
                got_done = 1'b1;
                break;
            end
            if (road_valid) begin
                if (held >= 0) check(int'(road_idx) == held, "R9 hold", int'(road_idx), held);
                if (k < ne) check(int'(road_idx) == exp_idx[k], tag, int'(road_idx), exp_idx[k]);
                else check(1'b0, tag, int'(road_idx), -1);
                if (rdy) begin k++; held = -1; last = t; end
                else held = int'(road_idx);
            end
            @(negedge clk);
        end
        road_ready = 1'b0;
        check(got_done, "R10 done seen", int'(got_done), 1);
        check(k == ne, tag, k, ne);
        check(t == last + 2, "R10 done timing", t, last + 2);
        check(!road_valid, "R10 valid low at done", int'(road_valid), 0);
        @(negedge clk);
        check(!road_done, "R10 single pulse", int'(road_done), 0);
    endtask

    task automatic full_hits(input int p);
        for (int l = 0; l < NL; l++) if (!m_wild[p][l]) add_hit(l, m_ssid[p][l]);
    endtask

    initial begin
        int skip;
        for (int l = 0; l < NL; l++) m_dc[l] = 0;
        for (int p = 0; p < NP; p++) for (int l = 0; l < NL; l++) begin
            m_ssid[p][l] = '0; m_wild[p][l] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!road_valid, "R1 reset valid", int'(road_valid), 0);
        check(!road_done, "R1 reset done", int'(road_done), 0);
        eoe = 1'b1; @(negedge clk); eoe = 1'b0;
        skip = 0;
        repeat (4) begin
            if (road_valid || road_done) skip++;
            @(negedge clk);
        end
        check(skip == 0, "R1 stray eoe", skip, 0);

        for (int p = 0; p < NP; p++) for (int l = 0; l < NL; l++)
            write_layer(p, l, SW'((p * 37 + l * 151 + 5) % 4096),
                        ((p % 3 == 0) && (l == p % 8)) || ((p % 5 == 0) && (l == (p + 3) % 8)));

        // R2, R4, R7: complete sets, some layers wildcard, plus near misses after.
        for (int p = 0; p < NP; p++) begin
            nh = 0;
            full_hits(p);
            for (int l = 0; l < NL; l++) add_hit(l, m_ssid[p][l] ^ 12'h800);
            run_event(p[0], "R2 full set");
        end
        // R4: wildcard-only missing layers, hits limited to non-wild.
        nh = 0; full_hits(0); full_hits(15);
        run_event(1'b1, "R4 wildcard pair");

        // R3: one required layer absent.
        for (int p = 0; p < NP; p++) begin
            nh = 0; skip = -1;
            for (int l = 0; l < NL; l++) begin
                if (!m_wild[p][l] && skip < 0) skip = l;
                else if (!m_wild[p][l]) add_hit(l, m_ssid[p][l]);
            end
            run_event(1'b0, "R3 missing layer");
        end

        // R7: hits while idle ignored, and a restart clears earlier hits.
        nh = 0; full_hits(1);
        drive_hits();
        sof = 1'b1; @(negedge clk); sof = 1'b0;
        drive_hits();
        nh = 0;
        run_event(1'b0, "R7 clear and idle");

        // R8: correct identifiers on layers 8..15 are dropped.
        for (int p = 0; p < NP; p += 3) begin
            nh = 0;
            for (int l = 0; l < NL; l++) add_hit(l + 8, m_ssid[p][l]);
            for (int l = 1; l < NL; l++) add_hit(l, m_ssid[p][l]);
            for (int i = 0; i < nh; i++) if (h_layer[i] == 0) h_layer[i] = 15;
            run_event(1'b1, "R8 out of range");
        end

        // R6: per-layer don't-care counts.
        for (int l = 0; l < NL; l++) set_dc(l, l);
        for (int p = 0; p < NP; p++) begin
            nh = 0;
            for (int l = 0; l < NL; l++) begin
                lfsr = step(lfsr);
                add_hit(l, m_ssid[p][l] ^ (SW'(lfsr) & ~({SW{1'b1}} << l)));
            end
            run_event(p[0], "R6 low bits ignored");
        end
        for (int p = 0; p < NP; p++) begin
            nh = 0;
            for (int l = 0; l < NL; l++)
                add_hit(l, (l == (p % 7) + 1 && !m_wild[p][l]) ? (m_ssid[p][l] ^ SW'(1 << l)) : m_ssid[p][l]);
            run_event(1'b0, "R6 bit above mask");
        end
        set_dc(7, 12);
        for (int p = 1; p < NP; p += 4) begin
            nh = 0;
            for (int l = 0; l < 7; l++) add_hit(l, m_ssid[p][l]);
            add_hit(7, 12'h000);
            run_event(1'b1, "R6 full mask");
        end
        for (int l = 0; l < NL; l++) set_dc(l, 0);

        // R5: third wildcard refused, second accepted.
        write_layer(0, 5, m_ssid[0][5], 1'b1);
        write_layer(3, 6, m_ssid[3][6], 1'b1);
        nh = 0;
        for (int l = 0; l < NL; l++) if (l != 5 && !m_wild[0][l]) add_hit(l, m_ssid[0][l]);
        run_event(1'b0, "R5 third wildcard");
        nh = 0;
        for (int l = 0; l < NL; l++) if (l != 6 && l != 3) add_hit(l, m_ssid[3][l]);
        run_event(1'b0, "R5 second wildcard");
        nh = 0; full_hits(0);
        run_event(1'b1, "R5 identifier kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule